// File: doc/BRIEF.md
# SPI Register Reader with Late-Latch Address Protection

This block is an SPI master that fetches single byte registers from a peripheral whose serial port latches the final command bit late. If the data-out line moves between the eighth rising clock edge and the falling edge that follows, that peripheral sees the address least significant bit as zero. An odd register then reads back as its even neighbour.

The block guards against this in two ways. First, the data-out line is never moved once the eighth command bit has been launched. It holds that value until chip select is released. Second, an aligned mode turns a request for an odd register into a two-byte read that starts at the even register below it. The block keeps only the second byte, which is the register that was asked for. An even register in aligned mode, and any register in hold mode, is read with a single data byte.

A request is a 7-bit register address, a mode bit and a one-cycle start pulse. The result is one byte with a one-cycle done pulse.

The clock is SPI mode 3:
- SCLK idles high.
- The master changes MOSI on falling edges.
- The master samples MISO on rising edges.

SCLK is the system clock divided by the parameter `CLK_DIV`, which must be even and at least 4.

The controller is a four-state machine:
- `S_IDLE`: the bus is quiet. A start pulse latches the request, drives chip select low and moves to `S_LEAD`.
- `S_LEAD`: waits half an SCLK period. On the tick it makes the first falling edge and moves to `S_XFER`.
- `S_XFER`: makes one SCLK edge per tick. After the final rising edge it moves to `S_TAIL`.
- `S_TAIL`: waits half a period. On the tick it releases chip select, updates the result, pulses done and returns to `S_IDLE`.

Top module: `quirk_spi_reader`

## Requirements
- R1: cs_n is low for the whole of each transaction, and there is exactly one low period per accepted request. SCLK is high whenever cs_n is high. The first bit on MOSI is 1 (read), followed by the 7-bit wire address, most significant bit first.
- R2: Every SCLK level lasts CLK_DIV/2 system cycles. The first falling SCLK edge comes CLK_DIV/2 cycles after cs_n falls, and cs_n rises CLK_DIV/2 cycles after the final rising edge.
- R3: MOSI changes only in a cycle where SCLK falls. From the falling edge that launches the eighth command bit until cs_n rises, MOSI keeps that bit's value.
- R4: With align_mode = 0, the wire address equals the requested address and 8 data clocks follow. rdata is the byte sampled on those rising edges, MSB first.
- R5: With align_mode = 1 and an odd address, the wire address is the requested address with bit 0 cleared, and 16 data clocks follow. The first byte is discarded and rdata is the second byte, which belongs to the requested register.
- R6: With align_mode = 1 and an even address, the read is a single byte as in R4.
- R7: done is a one-cycle pulse in the cycle cs_n rises. rdata changes only together with done and holds its value otherwise.
- R8: busy is high from the cycle after an accepted start until done, and is low in the done cycle. A start that arrives while busy is ignored: it causes no extra transaction and leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, accepted only when idle |
| addr | input | 7 | Requested register address |
| align_mode | input | 1 | 0: hold-only strategy, 1: aligned two-byte read for odd addresses |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when rdata is valid |
| rdata | output | 8 | Byte of the requested register |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The peripheral model latches the address least significant bit on the falling edge after the eighth rising edge, and it returns 0x3F for register 0x0F. Because of that late latch, a MOSI change at the wrong moment turns into a wrong byte on rdata in that same transaction. A controller that strays from its state sequence shows up at the ports in one of three ways:
- chip select framing that is off by half a period or more;
- a count of data clocks other than 8 or 16;
- busy falling without done.

Each of these is visible within the transaction that went wrong.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
    localparam int CMD_BITS  = 8;
    localparam int ADDR_BITS = CMD_BITS - 1;
    localparam int BYTE_BITS = 8;
    localparam int MAX_BYTES = 2;
    // Edges per transaction: two per bit, command plus the longest data phase.
    localparam int EDGE_MAX  = 2 * (CMD_BITS + BYTE_BITS * MAX_BYTES);
    localparam int EDGE_W    = $clog2(EDGE_MAX);

    typedef enum logic [1:0] {
        S_IDLE,
        S_LEAD,
        S_XFER,
        S_TAIL
    } qsr_state_e;
endpackage

// File: rtl/qsr_tick.sv
module qsr_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == TOP) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == TOP);

    // Half periods are at least two cycles, so ticks never come back to back.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/qsr_xlate.sv
module qsr_xlate import qsr_pkg::*; (
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic                 align_mode,
    output logic [ADDR_BITS-1:0] wire_addr,
    output logic                 two_byte
);
    always_comb begin
        two_byte  = align_mode & req_addr[0];
        wire_addr = req_addr;
        if (two_byte) begin
            wire_addr[0] = 1'b0;
        end
    end
endmodule

// File: rtl/qsr_ctrl.sv
module qsr_ctrl import qsr_pkg::*; (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 tick,
    input  logic [ADDR_BITS-1:0] wire_addr,
    input  logic                 two_byte,
    input  logic                 miso,
    output logic                 busy,
    output logic                 done,
    output logic [BYTE_BITS-1:0] rdata,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi
);
    localparam logic [EDGE_W-1:0] LAST_ONE  = EDGE_W'(2 * (CMD_BITS + BYTE_BITS) - 1);
    localparam logic [EDGE_W-1:0] LAST_TWO  = EDGE_W'(EDGE_MAX - 1);
    localparam logic [EDGE_W-2:0] CMD_IDX   = (EDGE_W-1)'(CMD_BITS);
    localparam logic [EDGE_W-1:0] HOLD_FROM = EDGE_W'(2 * CMD_BITS);

    qsr_state_e state_q, state_d;

    logic [EDGE_W-1:0]    edge_cnt;
    logic [EDGE_W-1:0]    edge_now;
    logic [EDGE_W-1:0]    last_edge;
    logic [EDGE_W-2:0]    bit_idx;
    logic [CMD_BITS-1:0]  cmd_sh;
    logic [BYTE_BITS-1:0] rx_sh;
    logic                 two_byte_q;
    logic                 in_cmd;
    logic                 edge_go;

    assign last_edge = two_byte_q ? LAST_TWO : LAST_ONE;
    assign edge_now  = (state_q == S_LEAD) ? '0 : edge_cnt;
    assign bit_idx   = edge_now[EDGE_W-1:1];
    assign in_cmd    = bit_idx < CMD_IDX;
    assign edge_go   = tick && (state_q == S_LEAD || state_q == S_XFER);
    assign busy      = (state_q != S_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_LEAD;
            S_LEAD:  if (tick) state_d = S_XFER;
            S_XFER:  if (tick && edge_cnt == last_edge) state_d = S_TAIL;
            S_TAIL:  if (tick) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk       <= 1'b1;
            cs_n       <= 1'b1;
            mosi       <= 1'b1;
            done       <= 1'b0;
            rdata      <= '0;
            rx_sh      <= '0;
            cmd_sh     <= '0;
            edge_cnt   <= '0;
            two_byte_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == S_IDLE && start) begin
                cs_n       <= 1'b0;
                cmd_sh     <= {1'b1, wire_addr};
                two_byte_q <= two_byte;
                edge_cnt   <= '0;
            end
            if (edge_go) begin
                edge_cnt <= edge_now + 1'b1;
                if (!edge_now[0]) begin
                    sclk <= 1'b0;
                    if (in_cmd) begin
                        mosi   <= cmd_sh[CMD_BITS-1];
                        cmd_sh <= {cmd_sh[CMD_BITS-2:0], 1'b0};
                    end
                end else begin
                    sclk <= 1'b1;
                    if (!in_cmd) begin
                        rx_sh <= {rx_sh[BYTE_BITS-2:0], miso};
                    end
                end
            end
            if (state_q == S_TAIL && tick) begin
                cs_n  <= 1'b1;
                done  <= 1'b1;
                rdata <= rx_sh;
            end
        end
    end

    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    assert_cs_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
    assert_mosi_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $fell(sclk));
    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && edge_cnt > HOLD_FROM) |=> $stable(mosi));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_rdata_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));
    assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/quirk_spi_reader.sv
module quirk_spi_reader import qsr_pkg::*; #(
    parameter int CLK_DIV = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic                 align_mode,
    output logic                 busy,
    output logic                 done,
    output logic [BYTE_BITS-1:0] rdata,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    input  logic                 miso
);
    localparam int HALF = CLK_DIV / 2;

    logic                 tick;
    logic [ADDR_BITS-1:0] wire_addr;
    logic                 two_byte;

    qsr_tick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    qsr_xlate u_xlate (
        .req_addr  (addr),
        .align_mode(align_mode),
        .wire_addr (wire_addr),
        .two_byte  (two_byte)
    );

    qsr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .wire_addr(wire_addr),
        .two_byte (two_byte),
        .miso     (miso),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .mosi     (mosi)
    );
endmodule

// File: tb/sim_quirk_spi_reader.sv
module sim_quirk_spi_reader;
    localparam int CLK_DIV = 8;
    localparam int HALF = CLK_DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       align_mode = 1'b0;
    logic       miso = 1'b1;
    logic [6:0] addr = '0;
    logic       busy, done, sclk, cs_n, mosi;
    logic [7:0] rdata;

    always #2.5 clk = ~clk;

    quirk_spi_reader #(.CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .align_mode(align_mode), .busy(busy), .done(done), .rdata(rdata),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // Peripheral model state
    int         rises = 0, falls = 0, data_clks = 0, cs_count = 0;
    logic [7:0] cmd_seen = '0;
    logic [6:0] base = '0;
    logic       lsb_val = 1'b0;
    bit         hold_bad = 0, spacing_bad = 0;
    int         t_last_edge = 0, t_cs_rise = 0;
    logic       prev_cs = 1'b1, prev_sclk = 1'b1;

    function automatic logic [7:0] reg_val(input logic [6:0] a);
        if (a == 7'h0F) return 8'h3F;
        return 8'(a * 8'd29 + 8'd7);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge cs_n) begin
        rises = 0; falls = 0; data_clks = 0; cmd_seen = '0;
        hold_bad = 0; spacing_bad = 0; cs_count++;
    end

    always @(posedge sclk) if (cs_n === 1'b0) begin
        if (rises < 8) begin
            cmd_seen = {cmd_seen[6:0], mosi};
            if (rises == 7) lsb_val = mosi;
        end else begin
            data_clks++;
        end
        rises++;
    end

    // Late latch: the address LSB is taken at the falling edge after the eighth rise.
    always @(negedge sclk) if (cs_n === 1'b0) begin
        int j;
        logic [7:0] b;
        if (falls == 8) base = {cmd_seen[6:1], mosi};
        if (falls >= 8) begin
            j = falls - 8;
            b = reg_val(7'(base + 7'(j / 8)));
            miso = b[7 - (j % 8)];
        end
        falls++;
    end

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !cs_n) t_last_edge = cyc;
        if (!prev_cs && cs_n) t_cs_rise = cyc;
        if (!cs_n && sclk !== prev_sclk) begin
            if (cyc - t_last_edge != HALF) spacing_bad = 1;
            t_last_edge = cyc;
        end
        if (!cs_n && rises >= 8 && mosi !== lsb_val) hold_bad = 1;
        prev_cs = cs_n;
        prev_sclk = sclk;
        if (cyc > 150000) begin
            chk(0, "WDOG", "watchdog expired", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic do_read(input logic [6:0] a, input logic m, input int inject);
        logic [6:0] ew;
        int         ec, c0, waitc;
        logic [7:0] ed, r0;
        bit         busy_ok;
        string      tag;
        ew  = (m && a[0]) ? {a[6:1], 1'b0} : a;
        ec  = (m && a[0]) ? 16 : 8;
        ed  = reg_val(a);
        tag = (m && a[0]) ? "R5" : (m ? "R6" : "R4");
        c0  = cs_count;
        @(negedge clk);
        start = 1'b1; addr = a; align_mode = m;
        @(negedge clk);
        start = 1'b0; addr = 7'($urandom % 128); align_mode = 1'($urandom % 2);
        chk(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
        waitc = 0; busy_ok = 1;
        while (done !== 1'b1 && waitc < 1000) begin
            if (busy !== 1'b1) busy_ok = 0;
            start = (waitc == inject);
            if (waitc == inject) begin addr = 7'h33; align_mode = 1'b1; end
            @(negedge clk);
            waitc++;
        end
        start = 1'b0;
        chk(done === 1'b1, "R7", "done arrives", int'(done), 1);
        chk(busy_ok && busy === 1'b0, "R8", "busy until done", int'(busy), 0);
        chk(rdata === ed, tag, "read data", int'(rdata), int'(ed));
        chk(cmd_seen[6:0] === ew, tag, "wire address", int'(cmd_seen[6:0]), int'(ew));
        chk(data_clks == ec, tag, "data clocks", data_clks, ec);
        chk(cmd_seen[7] === 1'b1, "R1", "read flag bit", int'(cmd_seen[7]), 1);
        r0 = rdata;
        @(negedge clk);
        chk(done === 1'b0, "R7", "done single cycle", int'(done), 0);
        chk(rdata === r0, "R7", "rdata held", int'(rdata), int'(r0));
        chk(cs_count == c0 + 1, "R1", "one cs_n low period", cs_count - c0, 1);
        chk(!spacing_bad, "R2", "edge spacing", int'(spacing_bad), 0);
        chk(t_cs_rise - t_last_edge == HALF, "R2", "cs_n trail", t_cs_rise - t_last_edge, HALF);
        chk(!hold_bad, "R3", "mosi held through data", int'(hold_bad), 0);
        if (inject >= 0) begin
            repeat (20) @(negedge clk);
            chk(cs_count == c0 + 1 && cs_n === 1'b1 && busy === 1'b0, "R8",
                "start while busy ignored", cs_count - c0, 1);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n === 1'b1, "R1", "reset cs_n", int'(cs_n), 1);
        chk(sclk === 1'b1, "R1", "reset sclk", int'(sclk), 1);
        chk(busy === 1'b0, "R8", "reset busy", int'(busy), 0);
        chk(done === 1'b0, "R7", "reset done", int'(done), 0);
        // Directed corners
        do_read(7'h0F, 1'b0, -1);
        do_read(7'h0F, 1'b1, -1);
        do_read(7'h0E, 1'b1, -1);
        do_read(7'h0E, 1'b0, -1);
        do_read(7'h7F, 1'b1, -1);
        do_read(7'h7F, 1'b0, -1);
        do_read(7'h00, 1'b1, -1);
        do_read(7'h01, 1'b0, -1);
        // Start pulses during a transaction
        do_read(7'h21, 1'b0, 12);
        do_read(7'h35, 1'b1, 60);
        // Random requests
        for (int i = 0; i < 40; i++) begin
            do_read(7'($urandom % 128), 1'($urandom % 2), -1);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule